// File: doc/BRIEF.md
# Flash Test Data Pattern Generator and Checker

This block makes and checks the test data that travels over a flash data path. A single start pulse arms one run. The run takes a seed word, a 2-bit pattern code and a word count, and works in one of two directions. In generate direction it offers the words of the sequence on an output stream. It offers either one word per beat, or, in double-rate mode, the words for indices i and i+1 together on one beat. In check direction it takes one read word per beat from an input stream. It compares each word with the value that the same seed and pattern predict, and it keeps a saturating count of mismatches and the index of the first one.

The pattern code selects constant data, data that rises by one per word, data that falls by one per word, or pseudo-random data. Pseudo-random data is checked under its own rule: the first word must equal the seed and every later word must be zero. Both streams use valid/ready handshakes. Flash bus timing and command sequencing happen outside this block. The data width may be at most 16 bits.

Top module: `flash_pattern_engine`

## Requirements
- R1: On the clock edge that samples start high, the block takes in seed, pattern, direction, double-rate mode and word count. The next cycle shows errCount = 0, errSeen = 0 and firstErrIdx = 0. It also shows busy = 1 and done = 0 when the count is nonzero, and busy = 0 and done = 1 when the count is zero.
- R2: Pattern code 2'b00 makes every word of index i equal to the seed.
- R3: Pattern code 2'b01 makes word i equal to (seed + i) modulo 2^DATA_W.
- R4: Pattern code 2'b10 makes word i equal to (seed - i) modulo 2^DATA_W.
- R5: Pattern code 2'b11 in generate direction makes word i equal to the low DATA_W bits of a 16-bit LFSR after i shifts. The LFSR starts from 16'hACE1 and shifts left, taking in bit15^bit13^bit12^bit10.
- R6: In double-rate generate mode, each beat carries word i on genData0 and word i+1 on genData1, and the index then advances by 2. An odd count therefore takes (N+1)/2 beats, and the last of these carries word N on genData1. In single-rate mode genData1 is 0 and the index advances by 1.
- R7: While genValid is high and genReady is low, genValid stays high and genData0 and genData1 hold their values.
- R8: Check direction takes one word per accepted beat, whatever the double-rate mode. For codes 00, 01 and 10 it expects the R2–R4 values. For code 11 it expects the seed at index 0 and 0 at every later index.
- R9: A received word that differs from the expected word in any bit raises errCount by one. errCount holds at 2^ERR_W-1 once it reaches that value.
- R10: The first mismatch of a run sets errSeen and stores its index in firstErrIdx. Later mismatches leave firstErrIdx unchanged.
- R11: In the cycle after the beat that consumes the last index, done = 1, busy = 0, genValid = 0 and chkReady = 0. These values hold until the next start.
- R12: genValid is high only in generate direction while busy, and chkReady is high only in check direction while busy. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that loads the run settings and clears results |
| checkRun | input | 1 | 1 = check direction, 0 = generate direction |
| ddrMode | input | 1 | 1 = two words per generate beat |
| patSel | input | 2 | Pattern code |
| seed | input | DATA_W | Seed word |
| wordCount | input | CNT_W | Number of words in the run |
| genValid | output | 1 | Generate stream valid |
| genReady | input | 1 | Generate stream ready |
| genData0 | output | DATA_W | Word at the current index |
| genData1 | output | DATA_W | Word at index+1 in double-rate mode, else 0 |
| chkValid | input | 1 | Check stream valid |
| chkData | input | DATA_W | Received read word |
| chkReady | output | 1 | Check stream ready |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| errCount | output | ERR_W | Saturating mismatch count |
| errSeen | output | 1 | At least one mismatch in this run |
| firstErrIdx | output | CNT_W | Index of the first mismatch |

## Verification
Generate words appear in the cycle after the start edge or after the previous accepted beat, and they hold while ready is low. The bench therefore drives inputs and reads outputs on the falling edge. It compares data in the same half-cycle in which it raises ready for the next rising edge. Mismatch results and done appear one cycle after the beat that causes them. The bench checks errCount, errSeen and firstErrIdx on the falling edge that follows the last accepted word, and it checks done and the dropped stream signals on that same edge.

// File: rtl/flash_pat_pkg.sv
package flash_pat_pkg;

  typedef enum logic [1:0] {
    PAT_CONST = 2'b00,
    PAT_INC   = 2'b01,
    PAT_DEC   = 2'b10,
    PAT_RAND  = 2'b11
  } patCode_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;    // new run: load settings, reset results
    logic genFire;  // generate beat accepted
    logic chkFire;  // check word accepted
  } fpeStrobe_t;

  // one left shift of the 16-bit maximal-length LFSR
  function automatic logic [15:0] lfsrStep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/fpe_ctrl.sv
module fpe_ctrl
  import flash_pat_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             checkRun,
  input  logic             ddrMode,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             genReady,
  input  logic             chkValid,
  output fpeStrobe_t       strb,
  output logic [CNT_W-1:0] idx,
  output logic             ddrLat,
  output logic             genValid,
  output logic             chkReady,
  output logic             busy,
  output logic             done
);

  logic             chkLat;
  logic [CNT_W-1:0] countLat;
  logic [CNT_W:0]   stepSum;
  logic             lastBeat;
  logic             fire;

  assign genValid = busy && !chkLat;
  assign chkReady = busy && chkLat;

  assign strb.clear   = start;
  assign strb.genFire = !start && genValid && genReady;
  assign strb.chkFire = !start && chkReady && chkValid;
  assign fire         = strb.genFire || strb.chkFire;

  assign stepSum  = {1'b0, idx} + ((chkLat || !ddrLat) ? (CNT_W+1)'(1) : (CNT_W+1)'(2));
  assign lastBeat = stepSum >= {1'b0, countLat};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chkLat   <= 1'b0;
      ddrLat   <= 1'b0;
      countLat <= '0;
      idx      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      chkLat   <= checkRun;
      ddrLat   <= ddrMode;
      countLat <= wordCount;
      idx      <= '0;
      busy     <= (wordCount != '0);
      done     <= (wordCount == '0);
    end else if (fire) begin
      if (lastBeat) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        idx <= stepSum[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/fpe_datapath.sv
module fpe_datapath
  import flash_pat_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          CNT_W     = 12,
  parameter int          ERR_W     = 8,
  parameter logic [15:0] LFSR_INIT = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fpeStrobe_t        strb,
  input  logic [CNT_W-1:0]  idx,
  input  logic              ddr,
  input  logic [1:0]        patSel,
  input  logic [DATA_W-1:0] seed,
  input  logic [DATA_W-1:0] chkData,
  output logic [DATA_W-1:0] genData0,
  output logic [DATA_W-1:0] genData1,
  output logic [ERR_W-1:0]  errCount,
  output logic              errSeen,
  output logic [CNT_W-1:0]  firstErrIdx
);

  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam int LANES = 2;

  patCode_t          patR;
  logic [DATA_W-1:0] seedR;
  logic [15:0]       lfsr;
  logic [15:0]       lfsrN1;
  logic [15:0]       lfsrN2;
  logic [DATA_W-1:0] expWord;
  logic              mismatch;

  assign lfsrN1 = lfsrStep(lfsr);
  assign lfsrN2 = lfsrStep(lfsrN1);

  // lane ln holds the word for index idx+ln
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [DATA_W-1:0] offs;
    logic [15:0]       st;
    logic [DATA_W-1:0] word;
    assign offs = DATA_W'(idx) + DATA_W'(ln);
    assign st   = (ln == 0) ? lfsr : lfsrN1;
    always_comb begin
      case (patR)
        PAT_CONST: word = seedR;
        PAT_INC:   word = seedR + offs;
        PAT_DEC:   word = seedR - offs;
        default:   word = st[DATA_W-1:0];
      endcase
    end
  end

  assign genData0 = g_lane[0].word;
  assign genData1 = ddr ? g_lane[1].word : '0;

  assign expWord  = (patR == PAT_RAND) ? ((idx == '0) ? seedR : '0) : g_lane[0].word;
  assign mismatch = |(expWord ^ chkData);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      patR        <= PAT_CONST;
      seedR       <= '0;
      lfsr        <= LFSR_INIT;
      errCount    <= '0;
      errSeen     <= 1'b0;
      firstErrIdx <= '0;
    end else if (strb.clear) begin
      patR        <= patCode_t'(patSel);
      seedR       <= seed;
      lfsr        <= LFSR_INIT;
      errCount    <= '0;
      errSeen     <= 1'b0;
      firstErrIdx <= '0;
    end else begin
      if (strb.genFire) lfsr <= ddr ? lfsrN2 : lfsrN1;
      if (strb.chkFire && mismatch) begin
        if (errCount != ERR_MAX) errCount <= errCount + 1'b1;
        if (!errSeen) begin
          errSeen     <= 1'b1;
          firstErrIdx <= idx;
        end
      end
    end
  end

endmodule

// File: rtl/flash_pattern_engine.sv
module flash_pattern_engine
  import flash_pat_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          CNT_W     = 12,
  parameter int          ERR_W     = 8,
  parameter logic [15:0] LFSR_INIT = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              checkRun,
  input  logic              ddrMode,
  input  logic [1:0]        patSel,
  input  logic [DATA_W-1:0] seed,
  input  logic [CNT_W-1:0]  wordCount,
  output logic              genValid,
  input  logic              genReady,
  output logic [DATA_W-1:0] genData0,
  output logic [DATA_W-1:0] genData1,
  input  logic              chkValid,
  input  logic [DATA_W-1:0] chkData,
  output logic              chkReady,
  output logic              busy,
  output logic              done,
  output logic [ERR_W-1:0]  errCount,
  output logic              errSeen,
  output logic [CNT_W-1:0]  firstErrIdx
);

  fpeStrobe_t       strb;
  logic [CNT_W-1:0] idx;
  logic             ddrLat;

  fpe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .checkRun(checkRun),
    .ddrMode(ddrMode), .wordCount(wordCount), .genReady(genReady),
    .chkValid(chkValid), .strb(strb), .idx(idx), .ddrLat(ddrLat),
    .genValid(genValid), .chkReady(chkReady), .busy(busy), .done(done)
  );

  fpe_datapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ERR_W(ERR_W), .LFSR_INIT(LFSR_INIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .idx(idx), .ddr(ddrLat),
    .patSel(patSel), .seed(seed), .chkData(chkData),
    .genData0(genData0), .genData1(genData1), .errCount(errCount),
    .errSeen(errSeen), .firstErrIdx(firstErrIdx)
  );

endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              genValid,
  input logic              genReady,
  input logic [DATA_W-1:0] genData0,
  input logic [DATA_W-1:0] genData1,
  input logic              chkReady,
  input logic              busy,
  input logic              done,
  input logic [ERR_W-1:0]  errCount,
  input logic              errSeen
);

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (errCount == '0 && !errSeen));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (genValid && !genReady && !start) |=> (genValid && $stable(genData0) && $stable(genData1)));

  assert_no_decrease_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (errCount >= $past(errCount)));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !genValid && !chkReady));

  assert_one_side_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(genValid && chkReady));

endmodule

bind flash_pattern_engine fpe_checker #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_fpe_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .genValid(genValid), .genReady(genReady),
  .genData0(genData0), .genData1(genData1), .chkReady(chkReady), .busy(busy),
  .done(done), .errCount(errCount), .errSeen(errSeen)
);

// File: tb/flash_pattern_engine_bench.sv
module flash_pattern_engine_bench;

  localparam int DW = 8;
  localparam int CW = 10;
  localparam int EW = 4;
  localparam int EMAX = (1 << EW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          checkRun = 1'b0;
  logic          ddrMode = 1'b0;
  logic [1:0]    patSel = 2'b00;
  logic [DW-1:0] seed = '0;
  logic [CW-1:0] wordCount = '0;
  logic          genReady = 1'b0;
  logic          chkValid = 1'b0;
  logic [DW-1:0] chkData = '0;
  logic          genValid, chkReady, busy, done, errSeen;
  logic [DW-1:0] genData0, genData1;
  logic [EW-1:0] errCount;
  logic [CW-1:0] firstErrIdx;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  flash_pattern_engine #(.DATA_W(DW), .CNT_W(CW), .ERR_W(EW)) u_flash_pattern_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .checkRun(checkRun), .ddrMode(ddrMode),
    .patSel(patSel), .seed(seed), .wordCount(wordCount), .genValid(genValid),
    .genReady(genReady), .genData0(genData0), .genData1(genData1),
    .chkValid(chkValid), .chkData(chkData), .chkReady(chkReady), .busy(busy),
    .done(done), .errCount(errCount), .errSeen(errSeen), .firstErrIdx(firstErrIdx)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsrAfter(input int n);
    logic [15:0] s = 16'hACE1;
    for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    return s;
  endfunction

  function automatic logic [DW-1:0] genExp(input logic [1:0] pat, input logic [DW-1:0] sd,
                                           input int i);
    logic [15:0] s;
    case (pat)
      2'b00: return sd;
      2'b01: return sd + DW'(i);
      2'b10: return sd - DW'(i);
      default: begin s = lfsrAfter(i); return s[DW-1:0]; end
    endcase
  endfunction

  function automatic logic [DW-1:0] chkExp(input logic [1:0] pat, input logic [DW-1:0] sd,
                                           input int i);
    if (pat == 2'b11) return (i == 0) ? sd : '0;
    return genExp(pat, sd, i);
  endfunction

  function automatic string patReq(input logic [1:0] pat);
    case (pat)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic startRun(input bit chk, input bit ddr, input logic [1:0] pat,
                          input logic [DW-1:0] sd, input int cnt);
    @(negedge clk);
    checkRun = chk; ddrMode = ddr; patSel = pat; seed = sd; wordCount = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == (cnt != 0), "R1", "busy after start", busy, cnt != 0);
    check(done == (cnt == 0), "R1", "done after start", done, cnt == 0);
    check(errCount == 0 && !errSeen && firstErrIdx == 0, "R1", "results cleared",
          errCount, 0);
  endtask

  task automatic runGen(input bit ddr, input logic [1:0] pat, input logic [DW-1:0] sd,
                        input int cnt);
    int i = 0;
    int beats = 0;
    startRun(1'b0, ddr, pat, sd, cnt);
    check(genValid == (cnt != 0) && !chkReady, "R12", "generate side only", genValid, cnt != 0);
    while (i < cnt) begin
      genReady = ($urandom % 4) != 0;
      if (genValid && genReady) begin
        check(genData0 == genExp(pat, sd, i), patReq(pat), "genData0", genData0, genExp(pat, sd, i));
        if (ddr)
          check(genData1 == genExp(pat, sd, i + 1), "R6", "genData1 pair", genData1,
                genExp(pat, sd, i + 1));
        else
          check(genData1 == 0, "R6", "genData1 zero in single rate", genData1, 0);
        i += ddr ? 2 : 1;
        beats++;
      end
      @(negedge clk);
      if (done && i < cnt) begin
        check(1'b0, "R11", "done early at index", i, cnt);
        break;
      end
    end
    genReady = 1'b0;
    check(done && !busy && !genValid, "R11", "done after final beat", done, 1);
    check(beats == (ddr ? (cnt + 1) / 2 : cnt), "R6", "beat count", beats,
          ddr ? (cnt + 1) / 2 : cnt);
  endtask

  task automatic runChk(input bit ddr, input logic [1:0] pat, input logic [DW-1:0] sd,
                        input int cnt, input int errPct, input int forceIdx);
    int i = 0;
    int expErr = 0;
    int first = -1;
    logic [DW-1:0] d;
    startRun(1'b1, ddr, pat, sd, cnt);
    check(!genValid && chkReady == (cnt != 0), "R12", "check side only", chkReady, cnt != 0);
    while (i < cnt) begin
      chkValid = chkReady && (($urandom % 3) != 0);
      if (chkValid) begin
        d = chkExp(pat, sd, i);
        if (i == forceIdx || int'($urandom % 100) < errPct) begin
          d = d ^ DW'(1 << ($urandom % DW));
          if (expErr < EMAX) expErr++;
          if (first < 0) first = i;
        end
        chkData = d;
        i++;
      end
      @(negedge clk);
    end
    chkValid = 1'b0;
    check(done && !busy && !chkReady, "R11", "done after last word", done, 1);
    check(errCount == EW'(expErr), expErr == 0 ? "R8" : "R9", "errCount", errCount, expErr);
    check(errSeen == (first >= 0), "R10", "errSeen", errSeen, first >= 0);
    if (first >= 0)
      check(firstErrIdx == CW'(first), "R10", "firstErrIdx", firstErrIdx, first);
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !genValid && !chkReady && errCount == 0, "R1", "reset state", busy, 0);

    // directed generate runs
    runGen(1'b0, 2'b00, 8'h5A, 6);
    runGen(1'b0, 2'b01, 8'hFD, 10);   // R3 wrap past 8'hFF
    runGen(1'b0, 2'b10, 8'h02, 8);    // R4 wrap below zero
    runGen(1'b0, 2'b11, 8'h00, 12);   // R5
    runGen(1'b1, 2'b01, 8'h10, 5);    // R6 odd count
    runGen(1'b1, 2'b11, 8'h00, 8);    // R6 with random lanes
    startRun(1'b0, 1'b0, 2'b00, 8'h00, 0);  // R11 zero count

    // directed check runs
    runChk(1'b0, 2'b00, 8'hC3, 9, 0, -1);   // R8 clean
    runChk(1'b1, 2'b11, 8'h77, 10, 0, -1);  // R8 random rule, ddr ignored
    runChk(1'b0, 2'b01, 8'h40, 30, 100, -1); // R9 saturation
    runChk(1'b0, 2'b10, 8'h11, 20, 0, 7);   // R10 single error
    runChk(1'b0, 2'b11, 8'h99, 12, 0, 0);   // R10 first word
    runChk(1'b0, 2'b01, 8'h20, 1, 0, -1);   // single word

    // constrained random mix
    for (int n = 0; n < 12; n++) begin
      runGen(1'($urandom), 2'($urandom), 8'($urandom), 1 + int'($urandom % 40));
      runChk(1'($urandom), 2'($urandom), 8'($urandom), 1 + int'($urandom % 40), 10, -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule